// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers the interrupt status of a serial audio converter. Three error
conditions arrive as level inputs: the serial port's word size is not 16 bits,
the external codec's word size is not 16 bits, and transmission started with an
empty transmit queue. Each condition is captured in a sticky flag that sets only
on a low-to-high transition of its input. Four status levels from the underlying
synchronous serial port (transmit queue, receive queue, receive timeout, receive
overrun) are registered once and reported without latching.

A small word-addressed register bus gives software four views. Word 0 is the raw
status (read-only). Word 1 is the enable mask (read/write). Word 2 is the raw
status ANDed with the mask (read-only). Word 3 is the write-one-to-clear port for
the three error flags. Read data is combinational from the address. One interrupt
line is the OR of the masked status.

Each error flag is tracked by a four-state machine. The states are `EG_IDLE` (flag
clear, input last seen low), `EG_SET_HI` (flag set, input last seen high),
`EG_SET_LO` (flag set, input last seen low) and `EG_WAIT` (flag clear, input still
high after a clear). The transitions are as follows:
- `EG_IDLE` goes to `EG_SET_HI` when the input is high (rise).
- `EG_SET_HI` goes to `EG_SET_LO` when the input falls and there is no clear. It goes to `EG_WAIT` on a clear with the input high, and to `EG_IDLE` on a clear with the input low.
- `EG_SET_LO` goes to `EG_SET_HI` when the input rises, whether or not a clear is present. It goes to `EG_IDLE` on a clear with the input low.
- `EG_WAIT` goes to `EG_IDLE` when the input falls.

In every other case the state holds.

Top module: `audio_irq_status`

## Requirements
- R1: While reset is asserted and right out of reset, the raw status word reads 0x00000008, the mask reads 0 and `irq_o` is 0.
- R2: Bits 31 to 7 of every readable word read as 0, and a write to word 0 (raw status) changes nothing.
- R3: A rising edge on `err_lvl[0]` sets raw bit 4 (underrun), on `err_lvl[1]` sets bit 5 (codec word size) and on `err_lvl[2]` sets bit 6 (port word size). The bit is visible one clock after the input is sampled high.
- R4: A set error bit stays 1 after its input falls, until it is cleared.
- R5: Writing word 3 with a 1 in bit 4, 5 or 6 clears that flag on the next clock. Bits written as 0 leave their flags untouched.
- R6: A flag cleared while its input is still high stays 0 until the input goes low and then high again.
- R7: If a clear of a flag and a new rising edge of its input fall in the same cycle, the flag stays 1.
- R8: Raw bits 3 to 0 equal `port_lvl` as sampled on the previous clock, and writing 1s to bits 3 to 0 of word 3 has no effect on them.
- R9: Word 1 holds bits 6 to 0 of the last value written to it. Word 2 reads the raw status ANDed with word 1.
- R10: `irq_o` is 1 exactly when word 2 is nonzero.
- R11: An error input that is already high when reset is released sets its flag once. After a clear, the flag stays 0 while the input remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_lvl | input | 3 | Error condition levels: [0] underrun, [1] codec size, [2] port size |
| port_lvl | input | 4 | Serial port status levels for raw bits 3..0 |
| bus_wr | input | 1 | Write strobe, sampled on the clock |
| bus_addr | input | 2 | Word address: 0 raw, 1 mask, 2 masked, 3 clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every stored result lands one clock after its cause is sampled. This covers a flag set by an error edge, a flag cleared by a word 3 write, a new mask value and a new level on bits 3 to 0. Read data and `irq_o` follow the stored state and the address with no further delay. The bench changes inputs and starts writes on a falling edge, so exactly one rising edge separates a stimulus from the next falling edge. It then sets the read address and samples 2 ns after that falling edge or a later one, when the result has already settled. Each expected word is queued by the driver and compared by a monitor at that point. The monitor also checks that a held flag keeps its value over several more cycles.

// File: rtl/airq_pkg.sv
package airq_pkg;
    typedef enum logic [1:0] {
        EG_IDLE   = 2'd0,
        EG_SET_HI = 2'd1,
        EG_SET_LO = 2'd2,
        EG_WAIT   = 2'd3
    } edge_st_t;

    localparam int unsigned W_RAW  = 0;
    localparam int unsigned W_MASK = 1;
    localparam int unsigned W_MSKD = 2;
    localparam int unsigned W_CLR  = 3;
endpackage

// File: rtl/airq_edge_fsm.sv
module airq_edge_fsm
    import airq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    input  logic clr_i,
    output logic flag_o
);
    edge_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EG_IDLE:   if (in_i) st_d = EG_SET_HI;
            EG_SET_HI: begin
                if (clr_i)      st_d = in_i ? EG_WAIT : EG_IDLE;
                else if (!in_i) st_d = EG_SET_LO;
            end
            EG_SET_LO: begin
                if (in_i)       st_d = EG_SET_HI;
                else if (clr_i) st_d = EG_IDLE;
            end
            EG_WAIT:   if (!in_i) st_d = EG_IDLE;
            default:   st_d = EG_IDLE;
        endcase
    end

    always_comb begin
        unique case (st_q)
            EG_SET_HI, EG_SET_LO: flag_o = 1'b1;
            default:              flag_o = 1'b0;
        endcase
    end

    // R3 and R7: a rise sets the flag even when a clear arrives with it
    assert_set_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_i) |=> flag_o);
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !in_i) |=> !flag_o);
    assert_no_reset_while_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !flag_o && in_i && $past(in_i)) |=> !flag_o);
endmodule

// File: rtl/airq_regbank.sv
module airq_regbank
    import airq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned N_ERR  = 3,
    parameter int unsigned N_LVL  = 4,
    parameter logic [N_LVL-1:0] LVL_RST = 4'b1000,
    localparam int unsigned RAW_W = N_ERR + N_LVL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [N_ERR-1:0]  err_flags,
    input  logic [N_LVL-1:0]  port_lvl,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_ERR-1:0]  clr_vec,
    output logic              irq_o
);
    logic [N_LVL-1:0] lvl_q;
    logic [RAW_W-1:0] mask_q;
    logic [RAW_W-1:0] raw_w;
    logic [RAW_W-1:0] mskd_w;
    logic             wr_mask;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:RAW_W];
    assign wr_mask = bus_wr && (bus_addr == ADDR_W'(W_MASK));
    assign clr_vec = (bus_wr && (bus_addr == ADDR_W'(W_CLR))) ? bus_wdata[N_LVL +: N_ERR] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= LVL_RST;
            mask_q <= '0;
        end else begin
            lvl_q <= port_lvl;
            if (wr_mask) mask_q <= bus_wdata[RAW_W-1:0];
        end
    end

    assign raw_w  = {err_flags, lvl_q};
    assign mskd_w = raw_w & mask_q;
    assign irq_o  = |mskd_w;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(W_RAW):  bus_rdata[RAW_W-1:0] = raw_w;
            ADDR_W'(W_MASK): bus_rdata[RAW_W-1:0] = mask_q;
            ADDR_W'(W_MSKD): bus_rdata[RAW_W-1:0] = mskd_w;
            default:         bus_rdata = '0;
        endcase
    end

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:RAW_W] == '0);
    assert_level_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && bus_addr == ADDR_W'(W_RAW)) |-> bus_rdata[N_LVL-1:0] == $past(port_lvl));
    assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(W_MASK)) |=> mask_q == $past(bus_wdata[RAW_W-1:0]));
endmodule

// File: rtl/audio_irq_status.sv
module audio_irq_status
    import airq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned N_ERR  = 3,
    parameter int unsigned N_LVL  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ERR-1:0]  err_lvl,
    input  logic [N_LVL-1:0]  port_lvl,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [N_ERR-1:0] flags;
    logic [N_ERR-1:0] clr_vec;

    for (genvar g = 0; g < N_ERR; g++) begin : g_err
        airq_edge_fsm u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_i   (err_lvl[g]),
            .clr_i  (clr_vec[g]),
            .flag_o (flags[g])
        );
    end

    airq_regbank #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .N_ERR  (N_ERR),
        .N_LVL  (N_LVL)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .err_flags (flags),
        .port_lvl  (port_lvl),
        .bus_rdata (bus_rdata),
        .clr_vec   (clr_vec),
        .irq_o     (irq_o)
    );

    assert_irq_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(W_MSKD)) |-> (irq_o == (bus_rdata != '0)));
endmodule

// File: tb/sim_audio_irq_status.sv
`timescale 1ns/1ps
module sim_audio_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  err_lvl = '0;
    logic [3:0]  port_lvl = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [1:0]  addr;
        logic [31:0] data;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    audio_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .err_lvl(err_lvl), .port_lvl(port_lvl),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic rd(input logic [1:0] a, input logic [31:0] d, input logic q, input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr = a;
        e.addr = a; e.data = d; e.irq = q; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_in(input logic [2:0] e, input logic [3:0] l);
        @(negedge clk);
        err_lvl = e; port_lvl = l;
    endtask

    // monitor: pops expectations 2 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (bus_rdata !== e.data || irq_o !== e.irq) begin
                    bad++;
                    $display("FAIL %s addr=%0d data=%h irq=%b expected data=%h irq=%b",
                             e.tag, e.addr, bus_rdata, irq_o, e.data, e.irq);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rd(2'd0, 32'h08, 1'b0, "R1 raw in reset");
        rd(2'd1, 32'h00, 1'b0, "R1 mask in reset");
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0, 32'h00, 1'b0, "R8 levels low");
        set_in(3'b000, 4'b0101);
        rd(2'd0, 32'h05, 1'b0, "R8 levels 0101");
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'h05, 1'b0, "R2 raw write ignored");
        set_in(3'b001, 4'b0101);
        rd(2'd0, 32'h15, 1'b0, "R3 underrun bit4");
        set_in(3'b000, 4'b0101);
        rd(2'd0, 32'h15, 1'b0, "R4 sticky after fall");
        wr(2'd3, 32'h0000_000F);
        rd(2'd0, 32'h15, 1'b0, "R8 R5 low clear bits ignored");
        wr(2'd3, 32'h0000_0010);
        rd(2'd0, 32'h05, 1'b0, "R5 clear bit4");
        set_in(3'b100, 4'b0101);
        rd(2'd0, 32'h45, 1'b0, "R3 port size bit6");
        wr(2'd3, 32'h0000_0040);
        rd(2'd0, 32'h05, 1'b0, "R6 cleared while high");
        repeat (3) @(negedge clk);
        rd(2'd0, 32'h05, 1'b0, "R6 still clear");
        set_in(3'b000, 4'b0101);
        rd(2'd0, 32'h05, 1'b0, "R6 input dropped");
        set_in(3'b100, 4'b0101);
        rd(2'd0, 32'h45, 1'b0, "R6 rearmed rise");
        set_in(3'b110, 4'b0101);
        rd(2'd0, 32'h65, 1'b0, "R3 codec bit5");
        set_in(3'b100, 4'b0101);
        rd(2'd0, 32'h65, 1'b0, "R4 bit5 held");
        @(negedge clk);
        err_lvl = 3'b110; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h20;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(2'd0, 32'h65, 1'b0, "R7 set wins");
        rd(2'd0, 32'h65, 1'b0, "R7 still set");
        wr(2'd3, 32'h0000_0070);
        rd(2'd0, 32'h05, 1'b0, "R5 clear all");
        set_in(3'b000, 4'b0101);
        rd(2'd0, 32'h05, 1'b0, "R6 inputs low");
        wr(2'd1, 32'hFFFF_FF22);
        rd(2'd1, 32'h22, 1'b0, "R9 mask bits");
        rd(2'd2, 32'h00, 1'b0, "R9 R10 masked zero");
        set_in(3'b000, 4'b0010);
        rd(2'd0, 32'h02, 1'b1, "R10 irq from level");
        rd(2'd2, 32'h02, 1'b1, "R9 masked level");
        set_in(3'b010, 4'b0010);
        rd(2'd2, 32'h22, 1'b1, "R9 masked codec");
        set_in(3'b000, 4'b0000);
        wr(2'd3, 32'h0000_0020);
        rd(2'd2, 32'h00, 1'b0, "R10 irq drops");
        @(negedge clk);
        err_lvl = 3'b001; rst_n = 1'b0;
        rd(2'd0, 32'h08, 1'b0, "R1 raw reset again");
        rd(2'd1, 32'h00, 1'b0, "R1 mask reset");
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0, 32'h10, 1'b0, "R11 high at release sets");
        rd(2'd0, 32'h10, 1'b0, "R11 held");
        wr(2'd3, 32'h0000_0010);
        rd(2'd0, 32'h00, 1'b0, "R11 cleared");
        repeat (3) @(negedge clk);
        rd(2'd0, 32'h00, 1'b0, "R11 single event");
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule